// File: doc/BRIEF.md
# Level-and-Priority Ranked Interrupt Controller

This block gathers up to 63 level-sensitive interrupt inputs and presents one request toward a processor core. Each input has a small control byte that holds an interrupt level and a priority inside that level. Two 32-bit mask words enable or block the inputs. A software agent sets the control bytes and the mask words through a simple single-cycle register bus.

Every clock the block samples the inputs into a pending vector. It then picks, among the pending inputs that are unmasked and have a nonzero level, the one with the highest level and, within that level, the highest priority. It drives that input's level and source number to the core, and the core uses the source number as its vector.

Bit 0 of the low mask word does not belong to a source. When it is set, it blocks every source at once. Inputs 1 to 7 are external lines with a hard-wired rank. Inputs 8 to 63 are fully programmable.

Top module: `lvl_intc`

## Requirements
- R1: After reset both mask words read 32'hFFFF_FFFF, every programmable control byte reads 0, and irq_req_o, irq_level_o and irq_src_o are all 0. Whenever no request is active, irq_level_o and irq_src_o are 0.
- R2: A source n is blocked when its mask bit is 1 and enabled when it is 0. The mask bit sits at position n mod 32 of the word that bit 5 of n selects. The low word (address 7'h00) covers sources 0 to 31. The high word (address 7'h04) covers sources 32 to 63.
- R3: While bit 0 of the low mask word is 1, no source produces a request, whatever the other mask bits are.
- R4: The control byte of source n sits at address 7'h40 + n. Bits 5:3 hold the level and bits 2:0 hold the priority. Bits 7:6 ignore writes and read 0.
- R5: A source whose level field is 0 never requests, even when it is pending and unmasked.
- R6: Among the eligible sources, the winner is the one with the larger level. When the levels are equal, the larger priority wins.
- R7: When two eligible sources hold identical level and priority, the lower source number wins.
- R8: Pending state follows the inputs with a single register stage. A source can win from the first cycle after a clock edge at which its input is 1, and it stops requesting after the first edge at which its input is 0.
- R9: Sources 1 to 7 have fixed control bytes: the level equals the source number and the priority is 4. Bus writes to their addresses are ignored.
- R10: Input bit 0 is not a source and never causes a request.
- R11: A mask or control write takes effect on the outputs in the cycle right after the clock edge that accepts it. This holds even when a source input changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| src_irq_i | input | 64 | Level-sensitive source inputs, bit 0 unused |
| irq_req_o | output | 1 | A source is requesting |
| irq_level_o | output | 3 | Level of the winning source |
| irq_src_o | output | 6 | Number of the winning source |

## Verification
A register write to a mask word and a change of a source input can land on the same clock edge. Both then change the winner seen in the next cycle. The bench provokes this case directly: at one edge it raises source 40 and clears the high mask word. It judges the result by requiring source 40 on the outputs in the very next cycle and none in the cycle before. A table of mask and input patterns is then judged against an independent model of the level-then-priority ranking, including ties and level-0 sources.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;
  localparam int NUM_SRC   = 64;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int LVL_W     = 3;
  localparam int PRI_W     = 3;
  localparam int KEY_W     = LVL_W + PRI_W;
  localparam int NUM_FIXED = 7;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 7;
  localparam int PAGE_W    = ADDR_W - SRC_W;

  localparam logic [PRI_W-1:0]  FIX_PRI     = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_MASK_LO = 7'h00;
  localparam logic [ADDR_W-1:0] ADDR_MASK_HI = 7'h04;
  localparam logic [PAGE_W-1:0] CTRL_PAGE    = 1'b1;
endpackage

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
  import lvl_intc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_SRC-1:0]              mask_o,
  output logic                            mask_all_o,
  output logic [NUM_SRC-1:0][KEY_W-1:0]   key_o
);
  logic [DATA_W-1:0] mask_lo_q, mask_lo_d;
  logic [DATA_W-1:0] mask_hi_q, mask_hi_d;
  logic              mask_lo_en, mask_hi_en;
  logic              ctrl_hit;

  assign ctrl_hit = (addr_i[ADDR_W-1:SRC_W] == CTRL_PAGE);

  // next state for the mask words
  always_comb begin
    mask_lo_en = wr_i && (addr_i == ADDR_MASK_LO);
    mask_hi_en = wr_i && (addr_i == ADDR_MASK_HI);
    mask_lo_d  = wdata_i;
    mask_hi_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo_q <= '1;
    end else if (mask_lo_en) begin
      mask_lo_q <= mask_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi_q <= '1;
    end else if (mask_hi_en) begin
      mask_hi_q <= mask_hi_d;
    end
  end

  assign mask_o     = {mask_hi_q, mask_lo_q};
  assign mask_all_o = mask_lo_q[0];

  // per-source control bytes: none for slot 0, hard-wired for the external lines
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_ctrl
      if (gi == 0) begin : g_none
        assign key_o[gi] = '0;
      end else if (gi <= NUM_FIXED) begin : g_fixed
        assign key_o[gi] = {LVL_W'(gi), FIX_PRI};
      end else begin : g_prog
        logic             ctrl_en;
        logic [KEY_W-1:0] ctrl_d, ctrl_q;
        always_comb begin
          ctrl_en = wr_i && ctrl_hit && (addr_i[SRC_W-1:0] == SRC_W'(gi));
          ctrl_d  = wdata_i[KEY_W-1:0];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ctrl_q <= '0;
          end else if (ctrl_en) begin
            ctrl_q <= ctrl_d;
          end
        end
        assign key_o[gi] = ctrl_q;
      end
    end
  endgenerate

  // read mux
  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o = {{(DATA_W-KEY_W){1'b0}}, key_o[addr_i[SRC_W-1:0]]};
    end else if (addr_i == ADDR_MASK_LO) begin
      rdata_o = mask_lo_q;
    end else if (addr_i == ADDR_MASK_HI) begin
      rdata_o = mask_hi_q;
    end
  end
endmodule

// File: rtl/lvl_intc_pend.sv
module lvl_intc_pend
  import lvl_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               mask_all_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] act_o
);
  logic [NUM_SRC-1:0] pend_d, pend_q;

  // slot 0 is not a source
  always_comb begin
    pend_d    = src_i;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = pend_q & ~mask_i & {NUM_SRC{~mask_all_i}};
endmodule

// File: rtl/lvl_intc_arb.sv
module lvl_intc_arb
  import lvl_intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]            act_i,
  input  logic [NUM_SRC-1:0][KEY_W-1:0] key_i,
  output logic                          win_vld_o,
  output logic [KEY_W-1:0]              win_key_o,
  output logic [SRC_W-1:0]              win_idx_o
);
  localparam int NODES = 2 * NUM_SRC;

  // heap-ordered tree: node k combines 2k (lower numbers) and 2k+1
  logic             nv [1:NODES-1];
  logic [KEY_W-1:0] nk [1:NODES-1];
  logic [SRC_W-1:0] ni [1:NODES-1];

  genvar gl;
  generate
    for (gl = 0; gl < NUM_SRC; gl++) begin : g_leaf
      logic elig;
      assign elig             = act_i[gl] && (key_i[gl][KEY_W-1 -: LVL_W] != '0);
      assign nv[NUM_SRC + gl] = elig;
      assign nk[NUM_SRC + gl] = elig ? key_i[gl] : '0;
      assign ni[NUM_SRC + gl] = elig ? SRC_W'(gl) : '0;
    end
    for (gl = 1; gl < NUM_SRC; gl++) begin : g_node
      logic take_r;
      // right side wins only when strictly larger; equal keeps the lower number
      assign take_r = nv[2*gl+1] && (!nv[2*gl] || (nk[2*gl+1] > nk[2*gl]));
      assign nv[gl] = nv[2*gl] || nv[2*gl+1];
      assign nk[gl] = take_r ? nk[2*gl+1] : nk[2*gl];
      assign ni[gl] = take_r ? ni[2*gl+1] : ni[2*gl];
    end
  endgenerate

  assign win_vld_o = nv[1];
  assign win_key_o = nk[1];
  assign win_idx_o = ni[1];
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] src_irq_i,
  output logic               irq_req_o,
  output logic [LVL_W-1:0]   irq_level_o,
  output logic [SRC_W-1:0]   irq_src_o
);
  logic [1:0]                      rst_sync_q;
  logic                            rst_sync_n;
  logic [NUM_SRC-1:0]              mask_vec;
  logic                            mask_all;
  logic [NUM_SRC-1:0][KEY_W-1:0]   key_vec;
  logic [NUM_SRC-1:0]              pend_vec;
  logic [NUM_SRC-1:0]              act_vec;
  logic                            win_vld;
  logic [KEY_W-1:0]                win_key;
  logic [SRC_W-1:0]                win_idx;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  lvl_intc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .mask_o     (mask_vec),
    .mask_all_o (mask_all),
    .key_o      (key_vec)
  );

  lvl_intc_pend u_pend (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .src_i      (src_irq_i),
    .mask_i     (mask_vec),
    .mask_all_i (mask_all),
    .pend_o     (pend_vec),
    .act_o      (act_vec)
  );

  lvl_intc_arb u_arb (
    .act_i      (act_vec),
    .key_i      (key_vec),
    .win_vld_o  (win_vld),
    .win_key_o  (win_key),
    .win_idx_o  (win_idx)
  );

  assign irq_req_o   = win_vld;
  assign irq_level_o = win_key[KEY_W-1 -: LVL_W];
  assign irq_src_o   = win_idx;
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
  import lvl_intc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] mask_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic               req_i,
  input logic [LVL_W-1:0]   lvl_i,
  input logic [SRC_W-1:0]   idx_i
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |-> (lvl_i == '0 && idx_i == '0));

  assert_winner_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> !mask_i[idx_i]);

  assert_mask_all_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i[0] |-> !req_i);

  assert_level_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> lvl_i != '0);

  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> pend_i[idx_i]);

  assert_slot0_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |-> idx_i != '0);
endmodule

bind lvl_intc lvl_intc_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .mask_i (mask_vec),
  .pend_i (pend_vec),
  .req_i  (irq_req_o),
  .lvl_i  (irq_level_o),
  .idx_i  (irq_src_o)
);

// File: tb/lvl_intc_tb.sv
module lvl_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] src;
  logic        irq_req;
  logic [2:0]  irq_lvl;
  logic [5:0]  irq_src;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_lo, m_hi;
  logic [5:0]  m_key [64];

  always #5 clk = ~clk;

  lvl_intc dut_i (
    .clk (clk), .rst_n (rst_n), .bus_wr_i (bus_wr), .bus_addr_i (bus_addr),
    .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata), .src_irq_i (src),
    .irq_req_o (irq_req), .irq_level_o (irq_lvl), .irq_src_o (irq_src)
  );

  // {mask_lo, mask_hi, inputs}
  localparam logic [127:0] VEC [8] = '{
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {32'h0000_0000, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {32'h0000_0000, 32'h0000_0000, 64'h0000_0000_0000_0100},
    {32'h0000_0001, 32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {32'h0000_00FE, 32'h0000_0000, 64'h0000_0000_FFFF_FFFE},
    {32'hFFFF_FFFE, 32'h0000_0000, 64'hFFFF_FFFF_0000_00FF},
    {32'h0000_0000, 32'hFFFF_FFFF, 64'h0000_0000_0000_00AA},
    {32'h0000_0000, 32'h0000_0000, 64'h0000_0000_0000_0001}
  };
  string vtag [8] = '{"R2", "R6", "R6", "R3", "R6", "R2", "R9", "R10"};

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic check_val(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(output logic ev, output logic [2:0] el, output logic [5:0] es);
    logic [63:0] mk;
    logic [5:0]  bk;
    mk = {m_hi, m_lo};
    ev = 1'b0; bk = '0; es = '0;
    for (int i = 1; i < 64; i++) begin
      if (src[i] && !mk[i] && !m_lo[0] && m_key[i][5:3] != 3'd0) begin
        if (!ev || m_key[i] > bk) begin
          ev = 1'b1; bk = m_key[i]; es = 6'(i);
        end
      end
    end
    el = bk[5:3];
  endtask

  task automatic check_out(string tag);
    logic ev; logic [2:0] el; logic [5:0] es;
    model(ev, el, es);
    n_chk++;
    if ({irq_req, irq_lvl, irq_src} !== {ev, el, es}) begin
      n_fail++;
      $display("FAIL %s: actual req=%0b lvl=%0d src=%0d expected req=%0b lvl=%0d src=%0d",
               tag, irq_req, irq_lvl, irq_src, ev, el, es);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic set_masks(input logic [31:0] lo, input logic [31:0] hi);
    bus_write(7'h00, lo); m_lo = lo;
    bus_write(7'h04, hi); m_hi = hi;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [5:0]  k;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    src = '1;
    m_lo = '1; m_hi = '1;
    for (int i = 0; i < 64; i++) m_key[i] = '0;
    for (int i = 1; i < 8; i++) m_key[i] = {3'(i), 3'd4};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(7'h00, rd); check_val("R1 mask lo", 64'(rd), 64'hFFFF_FFFF);
    bus_read(7'h04, rd); check_val("R1 mask hi", 64'(rd), 64'hFFFF_FFFF);
    bus_read(7'h40 + 7'd20, rd); check_val("R1 ctrl", 64'(rd), 64'd0);
    check_val("R1 outputs", {55'd0, irq_req, irq_lvl, irq_src}, 64'd0);

    // program control bytes with bits 7:6 set; multiples of 13 get level 0
    for (int n = 8; n < 64; n++) begin
      if (n % 13 == 0) k = {3'd0, 3'(n % 8)};
      else             k = {3'((n * 5) % 7 + 1), 3'((n * 3) % 8)};
      bus_write(7'h40 + 7'(n), {24'd0, 2'b11, k});
      m_key[n] = k;
    end
    bus_read(7'h40 + 7'd9, rd);  check_val("R4 ctrl readback", 64'(rd), 64'(m_key[9]));
    bus_read(7'h40 + 7'd63, rd); check_val("R4 ctrl readback hi", 64'(rd), 64'(m_key[63]));

    // R9 fixed byte ignores writes
    bus_write(7'h40 + 7'd3, 32'h0000_003F);
    bus_read(7'h40 + 7'd3, rd); check_val("R9 fixed ctrl", 64'(rd), 64'h1C);

    // table walk
    for (int v = 0; v < 8; v++) begin
      set_masks(VEC[v][127:96], VEC[v][95:64]);
      set_src(VEC[v][63:0]);
      check_out(vtag[v]);
    end

    // R5 level-0 source never requests
    set_masks(32'h0, 32'h0);
    set_src(64'd1 << 13);
    check_out("R5");
    check_val("R5 no req", 64'(irq_req), 64'd0);

    // R7 tie goes to the lower number
    bus_write(7'h40 + 7'd20, 32'h3F); m_key[20] = 6'h3F;
    bus_write(7'h40 + 7'd50, 32'h3F); m_key[50] = 6'h3F;
    set_src((64'd1 << 20) | (64'd1 << 50));
    check_val("R7 tie", {58'd0, irq_src}, 64'd20);

    // R8 one-register tracking
    set_src(64'd0);
    @(negedge clk); src = 64'd1 << 50; #1;
    check_val("R8 before edge", 64'(irq_req), 64'd0);
    @(negedge clk);
    check_val("R8 after edge", {57'd0, irq_req, irq_src}, {57'd0, 1'b1, 6'd50});
    src = 64'd0; #1;
    check_val("R8 held until edge", 64'(irq_req), 64'd1);
    @(negedge clk);
    check_val("R8 dropped", 64'(irq_req), 64'd0);

    // R2 bit mapping: source 40 uses high bit 8, source 8 uses low bit 8
    set_masks(32'hFFFF_FFFE, ~(32'd1 << 8));
    set_src((64'd1 << 8) | (64'd1 << 40));
    check_val("R2 high word", {58'd0, irq_src}, 64'd40);
    set_masks(32'hFFFF_FEFE, 32'hFFFF_FFFF);
    check_val("R2 low word", {58'd0, irq_src}, 64'd8);

    // R11 mask write and source change on the same edge
    set_masks(32'hFFFF_FFFE, 32'hFFFF_FFFF);
    set_src(64'd0);
    @(negedge clk);
    src = 64'd1 << 40;
    bus_wr = 1'b1; bus_addr = 7'h04; bus_wdata = 32'h0; #1;
    check_val("R11 before edge", 64'(irq_req), 64'd0);
    @(negedge clk);
    bus_wr = 1'b0; m_hi = 32'h0;
    check_out("R11");
    check_val("R11 src", {57'd0, irq_req, irq_src}, {57'd0, 1'b1, 6'd40});

    summary();
    $finish;
  end
endmodule